// File: doc/BRIEF.md
# Handshake Clock Domain Crossing Link

This block carries a multi-bit payload from one clock domain into a second, unrelated clock domain. A payload enters on the source side through a valid/ready pair. It is parked in a source-side holding register, and a request is raised toward the destination. The destination re-times that request, samples the parked payload and presents it for exactly one destination cycle. It then answers with an acknowledge that is re-timed back into the source domain. Only the two single-bit control signals pass through synchronizers. The payload bus is never synchronized: it is kept still for as long as the request is outstanding.

The signalling style is fixed when the block is built. In toggle mode, every edge of the request marks a new transfer, and the acknowledge copies the request back. In level mode, the request and the acknowledge each rise and then return to zero. This costs roughly twice the round trip of toggle mode. In both modes the source accepts nothing new until the whole synchronized round trip has finished.

Back-pressure rules: the source accepts a payload on a source clock edge where `src_valid` and `src_ready` are both high. `src_ready` drops on that edge and stays low until the handshake closes. While it is low, `src_valid` and `src_data` are ignored. The destination side has no back-pressure: each payload appears once, with `dst_valid` high for one cycle and `dst_data` valid in that cycle.

Top module: `hs_cdc_link`

## Requirements
- R1: After both resets, `src_ready` is 1 and `dst_valid` is 0, and no payload appears at the destination until one has been accepted.
- R2: Every accepted payload appears at the destination exactly once, in acceptance order, with `dst_data` equal to the accepted `src_data`.
- R3: `src_ready` is low in the source cycle right after an acceptance and stays low until the handshake completes. The holding register does not change while `src_ready` is low.
- R4: A `src_valid` presented while `src_ready` is low is ignored. Its data is neither delivered nor allowed to disturb the payload in flight.
- R5: In toggle mode (FOUR_PHASE=0), `src_ready` stays low for at least 3 source cycles per transfer. This covers the two-flop synchronizer on each control signal plus the response register on each side.
- R6: In level mode (FOUR_PHASE=1), `src_ready` stays low for at least 6 source cycles per transfer. The request falling back to zero produces no destination output.
- R7: The request reaches the destination logic through SYNC_STAGES (default 2) destination-clocked flops. The acknowledge returns through SYNC_STAGES source-clocked flops.
- R8: `dst_valid` is a single-cycle pulse: it is never high in two consecutive destination cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous |
| src_valid | input | 1 | Source offers a payload |
| src_data | input | DATA_W | Payload offered by the source |
| src_ready | output | 1 | Block can accept a payload this cycle |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous |
| dst_valid | output | 1 | One-cycle pulse marking a delivered payload |
| dst_data | output | DATA_W | Delivered payload, valid while dst_valid is high |

## Verification
The bench sweeps every 8-bit payload value through both signalling variants. It does this for a slow source with a fast destination, a fast source with a slower destination, and a near-equal ratio, comparing the delivered sequences in order. After each acceptance it keeps `src_valid` high with inverted data while `src_ready` is low. A design that ignored ready would then deliver extra or corrupted words. It also measures how long ready stays low. A link that dropped a synchronizer stage or released the source before the acknowledge returned would show fewer than 3 (toggle) or 6 (level) busy cycles. A level-mode destination that fired on both request edges would produce an unexpected second word, which the in-order scoreboard reports.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE     = 2'd0,
    SRC_WAIT_ACK = 2'd1,
    SRC_WAIT_REL = 2'd2
  } src_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hs_src_ctrl.sv
module hs_src_ctrl
  import hs_cdc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter bit FOUR_PHASE  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              ack_async,
  output logic              req_out,
  output logic [DATA_W-1:0] hold_out
);
  src_state_e        state_q, state_d;
  logic              req_q, req_d;
  logic              ack_s;
  logic              accept;
  logic [DATA_W-1:0] hold_q;

  // R7: acknowledge re-timed into the source domain
  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ack_async),
    .q    (ack_s)
  );

  assign in_ready = (state_q == SRC_IDLE);
  assign accept   = in_valid && in_ready;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    case (state_q)
      SRC_IDLE: begin
        if (in_valid) begin
          state_d = SRC_WAIT_ACK;
          req_d   = FOUR_PHASE ? 1'b1 : ~req_q;
        end
      end
      SRC_WAIT_ACK: begin
        if (FOUR_PHASE) begin
          if (ack_s) begin
            state_d = SRC_WAIT_REL;
            req_d   = 1'b0;
          end
        end else if (ack_s == req_q) begin
          state_d = SRC_IDLE;
        end
      end
      SRC_WAIT_REL: begin
        if (!ack_s) state_d = SRC_IDLE;
      end
      default: state_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRC_IDLE;
      req_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      if (accept) hold_q <= in_data;
    end
  end

  assign req_out  = req_q;
  assign hold_out = hold_q;

  // R3: parked payload does not move while the source is busy
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(hold_q));

  generate
    if (FOUR_PHASE) begin : g_chk_level
      // R6: busy while request or acknowledge has not returned to zero
      a_r6_busy_until_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q || ack_s) |-> !in_ready);
      // R4: request only rises from an acceptance
      a_r4_rise_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(accept));
    end else begin : g_chk_toggle
      // R5: busy while the toggle is unanswered
      a_r5_busy_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q != ack_s) |-> !in_ready);
      // R4: request only toggles from an acceptance
      a_r4_toggle_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q != $past(req_q)) |-> $past(accept));
    end
  endgenerate
endmodule

// File: rtl/hs_dst_ctrl.sv
module hs_dst_ctrl #(
  parameter int DATA_W      = 8,
  parameter bit FOUR_PHASE  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_async,
  input  logic [DATA_W-1:0] data_async,
  output logic              ack_out,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              req_s;
  logic              ack_q;
  logic              fire;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  // R7: request re-timed into the destination domain
  hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req_async),
    .q    (req_s)
  );

  generate
    if (FOUR_PHASE) begin : g_level
      assign fire = req_s && !ack_q;
    end else begin : g_toggle
      assign fire = req_s ^ ack_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      ack_q   <= req_s;
      valid_q <= fire;
      if (fire) data_q <= data_async;
    end
  end

  assign ack_out   = ack_q;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  // R8: one cycle per delivered payload
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  generate
    if (FOUR_PHASE) begin : g_chk_level
      // R6: delivery only on the acknowledge rising, never on its fall
      a_r6_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ack_q && !$past(ack_q)));
    end else begin : g_chk_toggle
      // R5: delivery coincides with an acknowledge toggle
      a_r5_pulse_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ack_q != $past(ack_q)));
    end
  endgenerate
endmodule

// File: rtl/hs_cdc_link.sv
module hs_cdc_link #(
  parameter int DATA_W      = 8,
  parameter bit FOUR_PHASE  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  logic              req_x;
  logic              ack_x;
  logic [DATA_W-1:0] payload_x;

  hs_src_ctrl #(
    .DATA_W     (DATA_W),
    .FOUR_PHASE (FOUR_PHASE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .in_valid (src_valid),
    .in_data  (src_data),
    .in_ready (src_ready),
    .ack_async(ack_x),
    .req_out  (req_x),
    .hold_out (payload_x)
  );

  hs_dst_ctrl #(
    .DATA_W     (DATA_W),
    .FOUR_PHASE (FOUR_PHASE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dst (
    .clk       (dst_clk),
    .rst_n     (dst_rst_n),
    .req_async (req_x),
    .data_async(payload_x),
    .ack_out   (ack_x),
    .out_valid (dst_valid),
    .out_data  (dst_data)
  );

  // R1: nothing delivered while the destination is held in reset
  a_r1_quiet_in_reset: assert property (@(posedge dst_clk)
    !dst_rst_n |-> !dst_valid);
endmodule

// File: tb/hs_cdc_link_test.sv
`timescale 1ns/1ps
module hs_cdc_link_test;
  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;
  int   src_half = 37;

  logic       src_valid [2];
  logic [7:0] src_data  [2];
  logic       src_ready [2];
  logic       dst_valid [2];
  logic [7:0] dst_data  [2];

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [7:0] expq0[$];
  logic [7:0] expq1[$];
  logic prev_v [2];

  always #10 dst_clk = ~dst_clk;
  always #(src_half * 1ns) src_clk = ~src_clk;

  hs_cdc_link #(.DATA_W(8), .FOUR_PHASE(1'b0), .SYNC_STAGES(2)) uut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid[0]),
    .src_data(src_data[0]), .src_ready(src_ready[0]), .dst_clk(dst_clk),
    .dst_rst_n(dst_rst_n), .dst_valid(dst_valid[0]), .dst_data(dst_data[0]));

  hs_cdc_link #(.DATA_W(8), .FOUR_PHASE(1'b1), .SYNC_STAGES(2)) uut_lvl (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid[1]),
    .src_data(src_data[1]), .src_ready(src_ready[1]), .dst_clk(dst_clk),
    .dst_rst_n(dst_rst_n), .dst_valid(dst_valid[1]), .dst_data(dst_data[1]));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic take_out(input int lane, input logic [7:0] got);
    logic [7:0] want;
    int sz;
    sz = (lane == 0) ? expq0.size() : expq1.size();
    if (sz == 0) begin
      check(1'b0, "R2/R6 unexpected delivery", got, -1);
    end else begin
      want = (lane == 0) ? expq0.pop_front() : expq1.pop_front();
      check(got == want, "R2 in-order payload", got, want);
    end
  endtask

  // destination monitor
  always @(negedge dst_clk) begin
    for (int l = 0; l < 2; l++) begin
      if (dst_rst_n && dst_valid[l]) begin
        check(!prev_v[l], "R8 single-cycle pulse", 2, 1);
        take_out(l, dst_data[l]);
      end
      prev_v[l] = dst_valid[l];
    end
  end

  task automatic send(input int lane, input logic [7:0] d);
    int busy;
    int min_busy;
    min_busy = (lane == 0) ? 3 : 6;
    @(negedge src_clk);
    while (!src_ready[lane]) @(negedge src_clk);
    src_valid[lane] = 1'b1;
    src_data[lane]  = d;
    if (lane == 0) expq0.push_back(d); else expq1.push_back(d);
    @(negedge src_clk);
    check(src_ready[lane] == 1'b0, "R3 ready drops after accept", src_ready[lane], 0);
    // R4: keep offering different data while busy; must be ignored
    src_data[lane] = ~d;
    busy = 1;
    @(negedge src_clk);
    src_valid[lane] = 1'b0;
    if (!src_ready[lane]) busy++;
    while (!src_ready[lane]) begin
      @(negedge src_clk);
      if (!src_ready[lane]) busy++;
    end
    if (lane == 0) check(busy >= min_busy, "R5 toggle round trip", busy, min_busy);
    else           check(busy >= min_busy, "R6 level round trip", busy, min_busy);
  endtask

  task automatic do_reset();
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    for (int l = 0; l < 2; l++) begin
      src_valid[l] = 1'b0;
      src_data[l]  = '0;
      prev_v[l]    = 1'b0;
    end
    #200;
    src_rst_n = 1'b1;
    #13;
    dst_rst_n = 1'b1;
    repeat (4) @(negedge src_clk);
    for (int l = 0; l < 2; l++) begin
      check(src_ready[l] == 1'b1, "R1 ready after reset", src_ready[l], 1);
      check(dst_valid[l] == 1'b0, "R1 no output after reset", dst_valid[l], 0);
    end
  endtask

  initial begin
    int halves [3];
    halves[0] = 37;
    halves[1] = 7;
    halves[2] = 11;
    for (int r = 0; r < 3; r++) begin
      src_half = halves[r];
      do_reset();
      for (int l = 0; l < 2; l++) begin
        for (int v = 0; v < 256; v++) send(l, v[7:0]);
      end
      repeat (40) @(negedge dst_clk);
      // R2 / R7: everything accepted has crossed through the synchronizers
      check(expq0.size() == 0, "R2 all toggle words delivered", expq0.size(), 0);
      check(expq1.size() == 0, "R2 all level words delivered", expq1.size(), 0);
      check(src_ready[0] && src_ready[1], "R3 ready back high when idle",
            {src_ready[0], src_ready[1]}, 3);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3_900_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule